// File: doc/BRIEF.md
# Power-Fail Store and Recall Controller

This block sequences the copying of a volatile SRAM into its shadow nonvolatile array (a store) and the copying back (a recall). It watches a supply-low flag that is already synchronised to `clk`, a software store request, a write-in-progress level and a completed-write pulse. In return it issues one-cycle start pulses for a store or a recall. It also drives a write-inhibit for the SRAM front end, plus a busy flag and a 2-bit mode code that keep SRAM access closed while a transfer runs. The erase, program, recall and write-grace durations are parameters counted in clock cycles.

A dirty flag records whether any write has finished since the last store or recall. When the supply drops, the block stores only if that flag is set. A software request always stores. If a write is still under way when the supply drops, the store waits up to a bounded grace window for it to finish. While the supply is low the block holds a pending recall and runs it once the supply comes back. A recall also runs right after reset, which stands for power-up.

No data flows through the block, so every pin is a plain level or pulse and nothing has a valid/ready handshake. The pulse inputs are sampled on each rising edge.

Top module: `pfsr_ctrl`

## Requirements
- R1: After reset is released with `supply_low` low, `recall_start` is high for exactly the first cycle. `xfer_mode` then reads 3 (recall) for RECALL_CYC cycles, after which the block is in normal mode. If `supply_low` is high at release, no recall starts until it falls. While reset is held, `wr_inhibit` is 1 and `store_start`, `recall_start` and `xfer_busy` are 0.
- R2: When the supply drops with no completed write since the last store or recall, and no write is under way, no store starts.
- R3: When the supply drops after a write has completed and no write is under way, `store_start` pulses in the cycle after the first edge that sees `supply_low`.
- R4: A one-cycle `sw_store_req` in normal mode always starts a store, with `store_start` high after that edge, whether or not any write has occurred.
- R5: Every store shows `xfer_mode`=1 (erase) for exactly ERASE_CYC cycles and then `xfer_mode`=2 (program) for exactly PROG_CYC cycles. `xfer_busy` is high throughout, and `store_start` is a single-cycle pulse.
- R6: If `wr_active` is high when the supply drops, the store decision waits for the write. Suppose the write's `wr_done` arrives on its last active edge, h edges after the drop is seen (h counted from 1). If h is at most GRACE_CYC+1, the store starts at edge min(h, GRACE_CYC)+1. If the write never completes within the window and no earlier write is pending, no store starts.
- R7: `wr_inhibit` is 0 in normal mode. It is 1 during the grace window, during any transfer and while waiting with the supply low.
- R8: When `supply_low` falls after a low-supply wait, `recall_start` pulses after the next edge, and `xfer_mode` reads 3 for RECALL_CYC cycles.
- R9: `sw_store_req` has no effect outside normal mode, that is during a recall, a store or a low-supply wait. No `store_start` follows it.
- R10: If the supply drops while a software store runs, that store completes and no second store starts.
- R11: The dirty flag clears when a store or recall completes, so a supply drop that follows with no new write starts no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| supply_low | input | 1 | Synchronised supply-below-threshold level |
| sw_store_req | input | 1 | Software store request pulse |
| wr_active | input | 1 | SRAM write in progress level |
| wr_done | input | 1 | Pulse on the last cycle of a completed SRAM write |
| store_start | output | 1 | One-cycle pulse at the start of a store |
| recall_start | output | 1 | One-cycle pulse at the start of a recall |
| wr_inhibit | output | 1 | Blocks new SRAM writes outside normal mode |
| xfer_busy | output | 1 | High while a store or recall runs; SRAM access disabled |
| xfer_mode | output | 2 | 0 none, 1 erase, 2 program, 3 recall |

## Verification
Every result appears one edge after the stimulus that causes it: a start pulse follows the request or supply edge that triggers it, and in the grace case it follows the edge that ends the write or the window. Each phase then lasts exactly its parameter count. The bench drives inputs and samples outputs 1 ns after each rising edge, and it counts edges from the stimulus. It compares the count at which `store_start` appears, and the run length of each `xfer_mode` value, against figures it works out from the parameters. The grace window is swept over every write length from one edge to two past the window.

// File: rtl/pfsr_pkg.sv
package pfsr_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP, ST_IDLE, ST_GRACE, ST_ERASE, ST_PROG, ST_LOWPWR, ST_RECALL
  } pfsr_state_e;

  localparam logic [1:0] MODE_NONE   = 2'd0;
  localparam logic [1:0] MODE_ERASE  = 2'd1;
  localparam logic [1:0] MODE_PROG   = 2'd2;
  localparam logic [1:0] MODE_RECALL = 2'd3;
endpackage

// File: rtl/pfsr_timer.sv
// Shared down-counter: loaded on each state entry, flags zero at the last cycle.
module pfsr_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pfsr_dirty.sv
// Tracks whether a write has completed since the last store or recall.
module pfsr_dirty (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_done,
  input  logic accept,
  input  logic clr,
  output logic dirty_now
);
  logic dirty_q;
  logic set_w;

  assign set_w = wr_done & accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dirty_q <= 1'b0;
    else if (clr)   dirty_q <= 1'b0;
    else if (set_w) dirty_q <= 1'b1;
  end

  // A write finishing in the deciding cycle already counts.
  assign dirty_now = dirty_q | set_w;
endmodule

// File: rtl/pfsr_seq.sv
module pfsr_seq
  import pfsr_pkg::*;
#(
  parameter int GRACE_CYC  = 4,
  parameter int ERASE_CYC  = 4,
  parameter int PROG_CYC   = 4,
  parameter int RECALL_CYC = 4,
  parameter int CW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_low,
  input  logic          sw_store_req,
  input  logic          wr_active,
  input  logic          dirty_now,
  input  logic          tmr_zero,
  output pfsr_state_e   st,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          clr_dirty,
  output logic          store_start,
  output logic          recall_start
);
  pfsr_state_e nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_PWRUP:  nxt = supply_low ? ST_LOWPWR : ST_RECALL;
      ST_IDLE: begin
        if (supply_low) begin
          if (wr_active)      nxt = ST_GRACE;
          else if (dirty_now) nxt = ST_ERASE;
          else                nxt = ST_LOWPWR;
        end else if (sw_store_req) begin
          nxt = ST_ERASE;
        end
      end
      ST_GRACE:
        if (!wr_active || tmr_zero) nxt = dirty_now ? ST_ERASE : ST_LOWPWR;
      ST_ERASE:  if (tmr_zero) nxt = ST_PROG;
      ST_PROG:   if (tmr_zero) nxt = supply_low ? ST_LOWPWR : ST_IDLE;
      ST_LOWPWR: if (!supply_low) nxt = ST_RECALL;
      ST_RECALL: if (tmr_zero) nxt = ST_IDLE;
      default:   nxt = ST_PWRUP;
    endcase
  end

  assign tmr_load  = (nxt != st);
  assign clr_dirty = tmr_zero && (st == ST_PROG || st == ST_RECALL);

  always_comb begin
    unique case (nxt)
      ST_GRACE:  tmr_val = CW'(GRACE_CYC - 1);
      ST_ERASE:  tmr_val = CW'(ERASE_CYC - 1);
      ST_PROG:   tmr_val = CW'(PROG_CYC - 1);
      ST_RECALL: tmr_val = CW'(RECALL_CYC - 1);
      default:   tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_PWRUP;
      store_start  <= 1'b0;
      recall_start <= 1'b0;
    end else begin
      st           <= nxt;
      store_start  <= (nxt == ST_ERASE)  && (st != ST_ERASE);
      recall_start <= (nxt == ST_RECALL) && (st != ST_RECALL);
    end
  end
endmodule

// File: rtl/pfsr_ctrl.sv
module pfsr_ctrl
  import pfsr_pkg::*;
#(
  parameter int GRACE_CYC  = 16,
  parameter int ERASE_CYC  = 32,
  parameter int PROG_CYC   = 64,
  parameter int RECALL_CYC = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_low,
  input  logic       sw_store_req,
  input  logic       wr_active,
  input  logic       wr_done,
  output logic       store_start,
  output logic       recall_start,
  output logic       wr_inhibit,
  output logic       xfer_busy,
  output logic [1:0] xfer_mode
);
  localparam int MAX_AB = (GRACE_CYC > ERASE_CYC) ? GRACE_CYC : ERASE_CYC;
  localparam int MAX_CD = (PROG_CYC > RECALL_CYC) ? PROG_CYC : RECALL_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = (MAXC < 2) ? 1 : $clog2(MAXC);

  pfsr_state_e   st;
  logic          tmr_load, tmr_zero, clr_dirty, dirty_now, accept_wr;
  logic [CW-1:0] tmr_val;

  assign accept_wr = (st == ST_IDLE) || (st == ST_GRACE);

  pfsr_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  pfsr_dirty dirty_i (
    .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .accept(accept_wr),
    .clr(clr_dirty), .dirty_now(dirty_now)
  );

  pfsr_seq #(
    .GRACE_CYC(GRACE_CYC), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
    .RECALL_CYC(RECALL_CYC), .CW(CW)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .sw_store_req(sw_store_req),
    .wr_active(wr_active), .dirty_now(dirty_now), .tmr_zero(tmr_zero), .st(st),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .clr_dirty(clr_dirty),
    .store_start(store_start), .recall_start(recall_start)
  );

  always_comb begin
    unique case (st)
      ST_ERASE:  xfer_mode = MODE_ERASE;
      ST_PROG:   xfer_mode = MODE_PROG;
      ST_RECALL: xfer_mode = MODE_RECALL;
      default:   xfer_mode = MODE_NONE;
    endcase
  end

  assign xfer_busy  = (xfer_mode != MODE_NONE);
  assign wr_inhibit = (st != ST_IDLE);
endmodule

// File: rtl/pfsr_ctrl_chk.sv
module pfsr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_low,
  input logic       sw_store_req,
  input logic       store_start,
  input logic       recall_start,
  input logic       wr_inhibit,
  input logic       xfer_busy,
  input logic [1:0] xfer_mode
);
  p_store_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |=> !store_start);

  p_store_opens_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> (xfer_mode == 2'd1));

  p_prog_after_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_mode == 2'd2 && $past(xfer_mode) != 2'd2) |-> $past(xfer_mode) == 2'd1);

  p_recall_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |-> (xfer_mode == 2'd3));

  p_busy_inhibits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |-> wr_inhibit);

  p_low_inhibits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_low && $past(supply_low)) |-> wr_inhibit);

  p_sw_ignored_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && sw_store_req) |=> !store_start);

  p_no_double_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> !$past(xfer_busy));
endmodule

bind pfsr_ctrl pfsr_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .sw_store_req(sw_store_req),
  .store_start(store_start), .recall_start(recall_start), .wr_inhibit(wr_inhibit),
  .xfer_busy(xfer_busy), .xfer_mode(xfer_mode)
);

// File: tb/pfsr_ctrl_tb_top.sv
`timescale 1ns/1ps
module pfsr_ctrl_tb_top;
  localparam int G = 4, E = 3, P = 5, R = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_low = 1'b0, sw_store_req = 1'b0, wr_active = 1'b0, wr_done = 1'b0;
  logic store_start, recall_start, wr_inhibit, xfer_busy;
  logic [1:0] xfer_mode;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pfsr_ctrl #(.GRACE_CYC(G), .ERASE_CYC(E), .PROG_CYC(P), .RECALL_CYC(R)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .sw_store_req(sw_store_req),
    .wr_active(wr_active), .wr_done(wr_done), .store_start(store_start),
    .recall_start(recall_start), .wr_inhibit(wr_inhibit), .xfer_busy(xfer_busy),
    .xfer_mode(xfer_mode)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Edges until store_start is seen (0 = none within max).
  task automatic wait_store(input int max, output int t);
    t = 0;
    for (int i = 1; i <= max; i++) begin
      tick();
      if (store_start) begin t = i; return; end
    end
  endtask

  task automatic run_len(input logic [1:0] m, output int n);
    n = 0;
    while (xfer_mode == m && n < 500) begin n++; tick(); end
  endtask

  task automatic check_store(input string req);
    int n1, n2;
    chk(store_start == 1'b1 && xfer_busy, req, store_start, 1);
    run_len(2'd1, n1);
    chk(n1 == E, {req, " erase length"}, n1, E);
    run_len(2'd2, n2);
    chk(n2 == P, {req, " program length"}, n2, P);
  endtask

  task automatic check_recall(input string req);
    int n;
    chk(recall_start == 1'b1, req, recall_start, 1);
    run_len(2'd3, n);
    chk(n == R, {req, " recall length"}, n, R);
  endtask

  task automatic go_idle();
    supply_low = 0; sw_store_req = 0; wr_active = 0; wr_done = 0;
    for (int i = 0; i < 200 && wr_inhibit; i++) tick();
  endtask

  initial begin
    int t, n, exp_t;
    #3;
    // R1: reset state
    chk(wr_inhibit && !store_start && !recall_start && !xfer_busy, "R1 reset", wr_inhibit, 1);
    tick(); rst_n = 1; tick();
    check_recall("R1 power-up recall");
    chk(!wr_inhibit && xfer_mode == 2'd0, "R7 normal mode", wr_inhibit, 0);

    // R2: clean drop, no store; R8: recall on return
    supply_low = 1; wait_store(12, t);
    chk(t == 0, "R2 clean drop", t, 0);
    chk(wr_inhibit && xfer_mode == 2'd0, "R7 low wait", wr_inhibit, 1);
    supply_low = 0; tick();
    check_recall("R8 recall after return");

    // R3: dirty drop stores next edge
    wr_done = 1; tick(); wr_done = 0;
    supply_low = 1; wait_store(12, t);
    chk(t == 1, "R3 dirty drop latency", t, 1);
    check_store("R5 auto store");
    go_idle(); tick(); tick();

    // R11: after store+recall, drop without writes gives no store
    supply_low = 1; wait_store(12, t);
    chk(t == 0, "R11 cleared after store", t, 0);
    go_idle();

    // R4: software store with no writes
    sw_store_req = 1; tick(); sw_store_req = 0;
    check_store("R4 software store");
    chk(!wr_inhibit && xfer_mode == 2'd0, "R7 back to normal", wr_inhibit, 0);

    // R11: software store cleared dirty
    supply_low = 1; wait_store(12, t);
    chk(t == 0, "R11 cleared after sw store", t, 0);
    // R9: request during low wait ignored
    sw_store_req = 1; wait_store(6, t);
    chk(t == 0, "R9 ignored in low wait", t, 0);
    sw_store_req = 0; supply_low = 0; tick();
    // R9: request during recall ignored
    chk(recall_start == 1'b1, "R9 recall running", recall_start, 1);
    sw_store_req = 1;
    for (int i = 0; i < R; i++) tick();
    sw_store_req = 0;
    chk(xfer_mode == 2'd0 && !store_start, "R9 recall ended", xfer_mode, 0);
    wait_store(6, t);
    chk(t == 0, "R9 ignored in recall", t, 0);

    // R10: drop during a software store
    wr_done = 1; tick(); wr_done = 0;
    sw_store_req = 1; tick(); sw_store_req = 0; supply_low = 1;
    check_store("R10 sw store completes");
    wait_store(15, t);
    chk(t == 0, "R10 no second store", t, 0);
    chk(wr_inhibit && xfer_mode == 2'd0, "R10 low wait", wr_inhibit, 1);
    go_idle();

    // R6: sweep the write length through the grace window (clean start)
    for (int h = 1; h <= G + 2; h++) begin
      t = 0;
      supply_low = 1;
      for (int e = 1; e <= G + 4 && t == 0; e++) begin
        wr_active = (e <= h); wr_done = (e == h);
        tick();
        if (e == 1) chk(wr_inhibit, "R7 grace inhibit", wr_inhibit, 1);
        if (store_start) t = e;
      end
      wr_active = 0; wr_done = 0;
      exp_t = (h <= G + 1) ? ((h < G ? h : G) + 1) : 0;
      chk(t == exp_t, $sformatf("R6 grace h=%0d", h), t, exp_t);
      if (t != 0) check_store("R6 store after grace");
      go_idle();
    end

    // R6: timeout with an earlier write pending still stores after the window
    wr_done = 1; tick(); wr_done = 0;
    supply_low = 1; wr_active = 1; wait_store(G + 4, t);
    chk(t == G + 1, "R6 grace timeout dirty", t, G + 1);
    go_idle();

    // R1: power-up with supply low waits for return
    rst_n = 0; supply_low = 1; tick(); rst_n = 1;
    n = 0;
    for (int i = 0; i < 5; i++) begin tick(); if (recall_start || xfer_busy) n++; end
    chk(n == 0 && wr_inhibit, "R1 power-up while low", n, 0);
    supply_low = 0; tick();
    check_recall("R1 recall after low power-up");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule